// File: doc/BRIEF.md
# Operand Bypass and Interlock Unit

This block sits beside the operand-fetch stage of a three-register pipeline and guards against stale register reads. Every cycle it takes the two source register addresses of the instruction in operand fetch and compares them with the destinations of the two instructions ahead of it, which it tracks itself from the stream of accepted instructions. For each source it picks where the ALU input comes from in the next stage: the register file, the ALU output looped back, or the final-stage result. It can also ask for the ALU output to be replaced by the memory data being fetched, and it can ask the decoder to hold off while it puts a bubble into the pipeline.

The bubble is only needed when the instruction directly ahead is a memory load and the current instruction does real arithmetic on the loaded value. When the current instruction is a move, meaning an OR with zero that copies its operand, the fetched memory word is routed onto the ALU output instead and no cycle is lost. After a one-cycle stall the load is two slots ahead, and the final-result path covers it.

The stall request is combinational in the cycle the hazard is seen. The selects and pass-through requests are registered and apply to the execute stage one cycle later.

Top module: `opnd_bypass_ilk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both selects read 0 (register file), both pass flags read 0, and the tracked history holds no valid destination, so no stall is raised.
- R2: A source that matches only the destination of the instruction two slots ahead drives its select to 2 (final-stage result) in the cycle after it is presented.
- R3: A match with the instruction one slot ahead takes precedence over a match two slots ahead, including when both slots name the same register.
- R4: A one-ahead match with a producer that is not a load gives select 1 (ALU output loop-back) and pass flag 0.
- R5: A one-ahead match with a load producer, when the current instruction is a move, gives pass flag 1 with select 0 for that source, and no stall.
- R6: A one-ahead match with a load producer, when the current instruction is not a move, raises the stall output in the same cycle. In the next cycle both selects read 0 and both pass flags read 0 (bubble).
- R7: A stall inserts a bubble into the history, so a stall never lasts two consecutive cycles. When the held instruction is presented again it receives select 2 for the load's destination.
- R8: A slot whose write enable was 0, a cycle with the valid input low, and a source whose enable is 0 never produce a match. With the valid input low there is no stall, and the following cycle shows selects 0 and pass flags 0.
- R9: With the zero-register option set (the default), register 0 never matches any destination.
- R10: The two sources are decided independently, so one source can be forwarded while the other reads the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | An instruction is presented in operand fetch |
| id_src_a | input | AW | First source register address |
| id_src_a_en | input | 1 | First source is read |
| id_src_b | input | AW | Second source register address |
| id_src_b_en | input | 1 | Second source is read |
| id_dst | input | AW | Destination register address |
| id_dst_we | input | 1 | Instruction writes its destination |
| id_is_load | input | 1 | Instruction's result comes from a memory fetch |
| id_is_move | input | 1 | Instruction's operation is OR-with-zero |
| stall_o | output | 1 | Insert bubble, decoder must not accept the next instruction |
| ex_sel_a | output | 2 | ALU first-input select for execute: 0 register file, 1 ALU loop-back, 2 final result |
| ex_sel_b | output | 2 | ALU second-input select, same encoding |
| ex_pass_a | output | 1 | Replace ALU output by fetched memory data (first source) |
| ex_pass_b | output | 1 | Replace ALU output by fetched memory data (second source) |

## Verification
Loop-back forwarding on one source and final-result forwarding on the other can fall in the same cycle. A stall on one source can also coincide with a pass-through or a forward request on the other. These are provoked by an exhaustive sweep in which each source independently hits the one-ahead slot, the two-ahead slot, both, or neither, with every mix of load producers and move or arithmetic consumers. A random stream over four registers adds more overlaps. A behavioural model in the bench predicts the stall in the presentation cycle and both selects and pass flags one cycle later, and every output is compared on every clock.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;

   typedef enum logic [1:0] {
      SEL_REGFILE  = 2'd0,
      SEL_ALU_LOOP = 2'd1,
      SEL_FINAL    = 2'd2
   } opsel_e;

   localparam int unsigned NUM_SRC   = 2;
   localparam int unsigned HIST_SLOT = 2;

endpackage

// File: rtl/opbyp_history.sv
module opbyp_history #(
   parameter int unsigned AW    = 5,
   parameter int unsigned DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_wr,
   input  logic [AW-1:0] push_dst,
   input  logic          push_ld,
   output logic          slot_wr  [DEPTH],
   output logic [AW-1:0] slot_dst [DEPTH],
   output logic          slot_ld  [DEPTH]
);

   if (DEPTH < 2) begin : g_depth_bad
      $error("opbyp_history: DEPTH must be at least 2");
   end
   if (AW < 1) begin : g_aw_bad
      $error("opbyp_history: AW must be at least 1");
   end

   // slot 0 is one ahead of operand fetch, slot 1 two ahead
   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_wr[k]  <= 1'b0;
               slot_dst[k] <= '0;
               slot_ld[k]  <= 1'b0;
            end else begin
               slot_wr[k]  <= push_wr;
               slot_dst[k] <= push_dst;
               slot_ld[k]  <= push_ld & push_wr;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_wr[k]  <= 1'b0;
               slot_dst[k] <= '0;
               slot_ld[k]  <= 1'b0;
            end else begin
               slot_wr[k]  <= slot_wr[k-1];
               slot_dst[k] <= slot_dst[k-1];
               slot_ld[k]  <= slot_ld[k-1];
            end
         end
      end
   end

   // R7
   property p_shift;
      @(posedge clk) disable iff (!rst_n)
         1'b1 |=> (slot_wr[1] == $past(slot_wr[0]));
   endproperty
   slot_shift_chk: assert property (p_shift);

   // R8
   property p_ld_needs_wr;
      @(posedge clk) disable iff (!rst_n)
         slot_ld[0] |-> slot_wr[0];
   endproperty
   load_implies_write_chk: assert property (p_ld_needs_wr);

endmodule

// File: rtl/opbyp_match.sv
module opbyp_match
   import opbyp_pkg::*;
#(
   parameter int unsigned AW        = 5,
   parameter int unsigned DEPTH     = 2,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic          src_en,
   input  logic [AW-1:0] src,
   input  logic          is_move,
   input  logic          slot_wr  [DEPTH],
   input  logic [AW-1:0] slot_dst [DEPTH],
   input  logic          slot_ld  [DEPTH],
   output opsel_e        sel_nxt,
   output logic          pass_nxt,
   output logic          need_stall
);

   logic src_live;
   logic hit_near;
   logic hit_far;

   if (ZERO_HARD) begin : g_zero_hard
      assign src_live = src_en & (src != '0);
   end else begin : g_zero_soft
      assign src_live = src_en;
   end

   assign hit_near = src_live & slot_wr[0] & (slot_dst[0] == src);
   assign hit_far  = src_live & slot_wr[1] & (slot_dst[1] == src);

   always_comb begin
      sel_nxt    = SEL_REGFILE;
      pass_nxt   = 1'b0;
      need_stall = 1'b0;
      if (hit_near) begin
         if (!slot_ld[0]) begin
            sel_nxt = SEL_ALU_LOOP;
         end else if (is_move) begin
            pass_nxt = 1'b1;
         end else begin
            need_stall = 1'b1;
         end
      end else if (hit_far) begin
         sel_nxt = SEL_FINAL;
      end
   end

   // R5
   always_comb begin
      pass_excl_stall_chk: assert (!(pass_nxt && need_stall));
   end

endmodule

// File: rtl/opnd_bypass_ilk.sv
module opnd_bypass_ilk
   import opbyp_pkg::*;
#(
   parameter int unsigned AW        = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          id_valid,
   input  logic [AW-1:0] id_src_a,
   input  logic          id_src_a_en,
   input  logic [AW-1:0] id_src_b,
   input  logic          id_src_b_en,
   input  logic [AW-1:0] id_dst,
   input  logic          id_dst_we,
   input  logic          id_is_load,
   input  logic          id_is_move,
   output logic          stall_o,
   output logic [1:0]    ex_sel_a,
   output logic [1:0]    ex_sel_b,
   output logic          ex_pass_a,
   output logic          ex_pass_b
);

   localparam int unsigned DEPTH = HIST_SLOT;
   localparam int unsigned NS    = NUM_SRC;

   if (AW < 1 || AW > 16) begin : g_aw_bad
      $error("opnd_bypass_ilk: AW out of range");
   end

   logic          slot_wr  [DEPTH];
   logic [AW-1:0] slot_dst [DEPTH];
   logic          slot_ld  [DEPTH];

   logic [AW-1:0] src_v  [NS];
   logic          src_e  [NS];
   opsel_e        sel_n  [NS];
   logic          pass_n [NS];
   logic [NS-1:0] stall_v;
   opsel_e        sel_q  [NS];
   logic          pass_q [NS];
   logic          stall_w;
   logic          accept;

   assign src_v[0] = id_src_a;
   assign src_v[1] = id_src_b;
   assign src_e[0] = id_src_a_en;
   assign src_e[1] = id_src_b_en;

   for (genvar s = 0; s < NS; s++) begin : g_src
      opbyp_match #(
         .AW        (AW),
         .DEPTH     (DEPTH),
         .ZERO_HARD (ZERO_HARD)
      ) i_match (
         .src_en     (src_e[s]),
         .src        (src_v[s]),
         .is_move    (id_is_move),
         .slot_wr    (slot_wr),
         .slot_dst   (slot_dst),
         .slot_ld    (slot_ld),
         .sel_nxt    (sel_n[s]),
         .pass_nxt   (pass_n[s]),
         .need_stall (stall_v[s])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q[s]  <= SEL_REGFILE;
            pass_q[s] <= 1'b0;
         end else if (accept) begin
            sel_q[s]  <= sel_n[s];
            pass_q[s] <= pass_n[s];
         end else begin
            sel_q[s]  <= SEL_REGFILE;
            pass_q[s] <= 1'b0;
         end
      end
   end

   assign stall_w = id_valid & (|stall_v);
   assign accept  = id_valid & ~stall_w;

   opbyp_history #(
      .AW    (AW),
      .DEPTH (DEPTH)
   ) i_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_wr  (accept & id_dst_we),
      .push_dst (id_dst),
      .push_ld  (id_is_load),
      .slot_wr  (slot_wr),
      .slot_dst (slot_dst),
      .slot_ld  (slot_ld)
   );

   assign stall_o   = stall_w;
   assign ex_sel_a  = sel_q[0];
   assign ex_sel_b  = sel_q[1];
   assign ex_pass_a = pass_q[0];
   assign ex_pass_b = pass_q[1];

   // R7
   property p_single_stall;
      @(posedge clk) disable iff (!rst_n)
         stall_o |=> !stall_o;
   endproperty
   single_stall_chk: assert property (p_single_stall);

   // R6
   property p_bubble;
      @(posedge clk) disable iff (!rst_n)
         stall_o |=> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0 && !ex_pass_a && !ex_pass_b);
   endproperty
   bubble_out_chk: assert property (p_bubble);

   // R8
   property p_idle;
      @(posedge clk) disable iff (!rst_n)
         !id_valid |-> !stall_o;
   endproperty
   idle_no_stall_chk: assert property (p_idle);

   // R5
   property p_pass_sel;
      @(posedge clk) disable iff (!rst_n)
         (ex_pass_a |-> ex_sel_a == 2'd0) and (ex_pass_b |-> ex_sel_b == 2'd0);
   endproperty
   pass_sel_zero_chk: assert property (p_pass_sel);

   // R3
   property p_sel_legal;
      @(posedge clk) disable iff (!rst_n)
         (ex_sel_a != 2'd3) && (ex_sel_b != 2'd3);
   endproperty
   sel_legal_chk: assert property (p_sel_legal);

endmodule

// File: tb/test_opnd_bypass_ilk.sv
`timescale 1ns/100ps
module test_opnd_bypass_ilk;

   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          id_valid;
   logic [AW-1:0] id_src_a, id_src_b, id_dst;
   logic          id_src_a_en, id_src_b_en, id_dst_we, id_is_load, id_is_move;
   logic          stall_o;
   logic [1:0]    ex_sel_a, ex_sel_b;
   logic          ex_pass_a, ex_pass_b;

   int n_cmp = 0;
   int n_bad = 0;

   // behavioural model state: index 0 = one ahead
   int h_wr[2], h_dst[2], h_ld[2];
   int e_sel[2], e_pass[2];

   always #2.5 clk = ~clk;

   opnd_bypass_ilk #(.AW(AW), .ZERO_HARD(1'b1)) i_opnd_bypass_ilk (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
      .id_src_a(id_src_a), .id_src_a_en(id_src_a_en),
      .id_src_b(id_src_b), .id_src_b_en(id_src_b_en),
      .id_dst(id_dst), .id_dst_we(id_dst_we),
      .id_is_load(id_is_load), .id_is_move(id_is_move),
      .stall_o(stall_o), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
      .ex_pass_a(ex_pass_a), .ex_pass_b(ex_pass_b)
   );

   task automatic cmp(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // 0 regfile, 1 loop, 2 final, 3 pass, 4 stall
   function automatic int ref_pick(input int src, input int en, input int mv);
      if (en == 0 || src == 0) return 0;
      if (h_wr[0] != 0 && h_dst[0] == src) begin
         if (h_ld[0] == 0) return 1;
         if (mv != 0) return 3;
         return 4;
      end
      if (h_wr[1] != 0 && h_dst[1] == src) return 2;
      return 0;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         h_wr[k] = 0; h_dst[k] = 0; h_ld[k] = 0; e_sel[k] = 0; e_pass[k] = 0;
      end
   endtask

   // one cycle: check registered outputs, drive, check stall, advance model
   task automatic step(input int v, input int sa, input int sae, input int sb, input int sbe,
                       input int d, input int we, input int ld, input int mv, output int stalled);
      int pa, pb, st;
      @(negedge clk);
      cmp("R2/R3/R4/R10", "ex_sel_a", ex_sel_a, e_sel[0]);
      cmp("R2/R3/R4/R10", "ex_sel_b", ex_sel_b, e_sel[1]);
      cmp("R5/R6", "ex_pass_a", ex_pass_a, e_pass[0]);
      cmp("R5/R6", "ex_pass_b", ex_pass_b, e_pass[1]);
      id_valid = v[0]; id_src_a = sa[AW-1:0]; id_src_a_en = sae[0];
      id_src_b = sb[AW-1:0]; id_src_b_en = sbe[0]; id_dst = d[AW-1:0];
      id_dst_we = we[0]; id_is_load = ld[0]; id_is_move = mv[0];
      #1;
      pa = ref_pick(sa, sae, mv);
      pb = ref_pick(sb, sbe, mv);
      st = (v != 0 && (pa == 4 || pb == 4)) ? 1 : 0;
      cmp("R6/R7/R8", "stall_o", stall_o, st);
      stalled = st;
      if (v != 0 && st == 0) begin
         e_sel[0]  = (pa == 3) ? 0 : pa;  e_pass[0] = (pa == 3) ? 1 : 0;
         e_sel[1]  = (pb == 3) ? 0 : pb;  e_pass[1] = (pb == 3) ? 1 : 0;
      end else begin
         e_sel[0] = 0; e_sel[1] = 0; e_pass[0] = 0; e_pass[1] = 0;
      end
      h_wr[1] = h_wr[0]; h_dst[1] = h_dst[0]; h_ld[1] = h_ld[0];
      h_wr[0] = (v != 0 && st == 0 && we != 0) ? 1 : 0;
      h_dst[0] = d; h_ld[0] = (h_wr[0] != 0 && ld != 0) ? 1 : 0;
   endtask

   // present until accepted (R7: at most one stall cycle)
   task automatic issue(input int sa, input int sae, input int sb, input int sbe,
                        input int d, input int we, input int ld, input int mv);
      int st;
      int tries = 0;
      do begin
         step(1, sa, sae, sb, sbe, d, we, ld, mv, st);
         tries++;
      end while (st != 0 && tries < 4);
      cmp("R7", "stall_cycles", tries, (tries > 2) ? 2 : tries);
   endtask

   task automatic idle();
      int st;
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, st);
   endtask

   initial begin
      fork
         begin
            #900000;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none
   end

   initial begin
      int st;
      rst_n = 1'b0;
      id_valid = 0; id_src_a = 0; id_src_a_en = 0; id_src_b = 0; id_src_b_en = 0;
      id_dst = 0; id_dst_we = 0; id_is_load = 0; id_is_move = 0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", "reset ex_sel_a", ex_sel_a, 0);
      cmp("R1", "reset ex_pass_b", ex_pass_b, 0);
      cmp("R1", "reset stall", stall_o, 0);
      rst_n = 1'b1;
      // R1: history empty, sources that would match get nothing
      step(1, 4, 1, 4, 1, 4, 1, 1, 0, st);
      cmp("R1", "no stall after reset", st, 0);

      // R5: move after load -> pass, R6: arithmetic after load -> stall
      idle(); idle();
      issue(0, 0, 0, 0, 6, 1, 1, 0);
      issue(6, 1, 2, 1, 8, 1, 0, 1);
      idle(); idle();
      issue(0, 0, 0, 0, 6, 1, 1, 0);
      issue(6, 1, 2, 1, 8, 1, 0, 0);
      // R8: write-disabled producer, disabled source, invalid cycle
      idle(); idle();
      issue(0, 0, 0, 0, 9, 0, 1, 0);
      issue(9, 1, 9, 1, 1, 1, 0, 0);
      issue(0, 0, 0, 0, 9, 1, 1, 0);
      issue(9, 0, 9, 0, 1, 1, 0, 0);
      step(0, 9, 1, 9, 1, 9, 1, 1, 0, st);
      // R9: register 0 never matches
      issue(0, 0, 0, 0, 0, 1, 0, 0);
      issue(0, 1, 0, 1, 3, 1, 0, 0);

      // exhaustive sweep: R2 R3 R4 R5 R6 R10
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++)
            for (int same = 0; same < 2; same++)
               for (int l1 = 0; l1 < 2; l1++)
                  for (int l2 = 0; l2 < 2; l2++)
                     for (int mv = 0; mv < 2; mv++) begin
                        int d1 = 7;
                        int d2 = (same != 0) ? 7 : 11;
                        int sa = (a == 0) ? 7 : (a == 1) ? 11 : 3;
                        int sb = (b == 0) ? 7 : (b == 1) ? 11 : 3;
                        idle(); idle();
                        issue(0, 0, 0, 0, d2, 1, l2, 0);
                        issue(0, 0, 0, 0, d1, 1, l1, 0);
                        issue(sa, 1, sb, 1, 14, 1, 0, mv);
                     end

      // random stream over a small register set
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom;
         step((r[0] | r[1]) ? 1 : 0, r[3:2], r[4], r[6:5], r[7], r[9:8], r[10] | r[11],
              r[12], r[13] & r[14], st);
      end
      idle(); idle();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule